// File: doc/BRIEF.md
# Bad Block Retirement and Spare Redirection Unit

This unit keeps track of which physical erase blocks of a flash array are unusable and silently steers host accesses away from them. Physical blocks are split into three groups: block 0 and the highest block hold the controller's own tables and are always treated as good; a contiguous pool of spare blocks sits just below the highest block and is invisible to the host; every remaining block is host-visible, and logical block L is physical block L until it is retired.

At start-up the factory-defect scan results are streamed in one block number at a time. A load-complete strobe then starts a sweep that gives every defective host block a spare. Afterwards the unit watches completion reports of program and erase operations. A report with a failure flag, or one that needed more retries than a programmable limit, retires the named block. A retired host block receives the lowest-numbered free, good spare. If the failing block is itself a spare in service, the host block it stood in for is moved to the next spare. A translate port returns the physical block for a logical block one cycle after the request. A warning output rises when too few spares remain, and a sticky fatal flag records that a retirement could not be served.

Top module: `bbt_remap`

## Requirements
- R1: Each block number loaded while the unit is in its load phase is entered in the defect set; after the sweep, a defective host block translates to a spare and reports good.
- R2: `ready` is low from reset through the load phase and the sweep, and rises when the sweep finishes; operation reports presented while `ready` is low change nothing.
- R3: An operation report with `op_fail` high retires the named block, and a later translation of that host block returns its replacement spare.
- R4: A report with `op_fail` low retires the block only when `op_retries` is strictly greater than `retry_limit`; a count equal to the limit leaves the block in service.
- R5: With NB blocks and NS spares, spare k is physical block NB-1-NS+k; spares are granted in ascending k, and a spare that is defective or already granted is skipped.
- R6: When a spare that serves a host block is retired, that host block is moved to the next available spare.
- R7: A report naming a block already in the defect set has no effect and consumes no spare.
- R8: Blocks 0 and NB-1 never enter the defect set and are never redirected; loads and reports naming them are ignored and logical 0 translates to physical 0, good.
- R9: `spare_warn` is high exactly when the count of spares that are neither defective nor granted is below `warn_level`.
- R10: A retirement that needs a spare when none is free raises `unrec` for one cycle and sets `fatal`, which stays high until reset; the affected host block then translates with `xl_ok` low.
- R11: A translate request yields `xl_out_vld` in the next cycle with the physical block in `xl_pblk`; a logical number at or above NB-1-NS returns itself with `xl_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_vld | input | 1 | Factory defect entry valid (load phase only) |
| init_blk | input | BW | Physical block number of the defect entry |
| init_done | input | 1 | End of defect list; starts the sweep |
| ready | output | 1 | High once the sweep has finished |
| op_vld | input | 1 | Operation completion report valid |
| op_blk | input | BW | Physical block the operation targeted |
| op_fail | input | 1 | Operation reported failure |
| op_retries | input | RW | Retries the operation needed |
| retry_limit | input | RW | Largest retry count still accepted |
| warn_level | input | CW | Spare count below which the warning rises |
| xl_vld | input | 1 | Translate request |
| xl_lblk | input | BW | Logical block to translate |
| xl_out_vld | output | 1 | Translate result valid |
| xl_pblk | output | BW | Physical block for the request |
| xl_ok | output | 1 | Result refers to a usable block |
| spare_warn | output | 1 | Remaining spares below `warn_level` |
| fatal | output | 1 | Sticky: a retirement found no spare |
| unrec | output | 1 | One-cycle pulse for an unserved retirement |

## Verification
The embedded assertions guard, on every cycle, the properties that hold regardless of history: the reserved blocks stay out of the defect set, a granted spare was free and good at the moment of the grant, the count of free spares never grows once running, a repeated report leaves that count unchanged, `fatal` never falls and always accompanies `unrec`, and translation answers with one cycle of latency while keeping logical 0 on physical 0. Which spare a given block receives, the skipping of a defective spare, the move of a host block off a failed spare, the exact retry boundary, the warning threshold and the state after exhaustion all depend on a sequence of events, so only the bench's directed scenarios can show them.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_SWEEP = 2'd1,
    PH_RUN   = 2'd2
  } bbt_phase_e;

  // Retirement by retry count: strictly more than the accepted limit.
  function automatic logic retries_exceed(input int unsigned tries,
                                          input int unsigned limit);
    return tries > limit;
  endfunction

endpackage

// File: rtl/bbt_spare_pick.sv
module bbt_spare_pick #(
  parameter int NS = 6,
  parameter int SW = 3,
  parameter int CW = 3
) (
  input  logic [NS-1:0] free_vec,
  output logic          avail,
  output logic [SW-1:0] pick,
  output logic [CW-1:0] remaining
);

  function automatic logic [SW-1:0] lowest_free(input logic [NS-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int k = NS - 1; k >= 0; k--) begin
      if (v[k]) r = SW'(k);
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] count_free(input logic [NS-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int k = 0; k < NS; k++) begin
      if (v[k]) c = c + CW'(1);
    end
    return c;
  endfunction

  assign avail     = |free_vec;
  assign pick      = lowest_free(free_vec);
  assign remaining = count_free(free_vec);

endmodule

// File: rtl/bbt_fail_judge.sv
module bbt_fail_judge
  import bbt_pkg::*;
#(
  parameter int NB = 32,
  parameter int BW = 5,
  parameter int RW = 4
) (
  input  logic          run,
  input  logic          op_vld,
  input  logic [BW-1:0] op_blk,
  input  logic          op_fail,
  input  logic [RW-1:0] op_retries,
  input  logic [RW-1:0] retry_limit,
  input  logic          blk_bad,
  output logic          mark
);

  logic reserved;
  logic failing;

  assign reserved = (op_blk == '0) || (int'(op_blk) >= NB - 1);
  assign failing  = op_fail || retries_exceed(int'(op_retries), int'(retry_limit));
  assign mark     = run && op_vld && failing && !reserved && !blk_bad;

endmodule

// File: rtl/bbt_xlate.sv
module bbt_xlate #(
  parameter int NB   = 32,
  parameter int BW   = 5,
  parameter int SW   = 3,
  parameter int LOGN = 25
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xl_vld,
  input  logic [BW-1:0]             xl_lblk,
  input  logic [LOGN-1:0]           map_v,
  input  logic [LOGN-1:0][SW-1:0]   map_s,
  input  logic [NB-1:0]             bad,
  output logic                      out_vld,
  output logic [BW-1:0]             out_pblk,
  output logic                      out_ok
);

  logic          in_rng;
  logic [BW-1:0] tgt;
  logic          ok_c;

  always_comb begin
    in_rng = int'(xl_lblk) < LOGN;
    tgt    = xl_lblk;
    if (in_rng && map_v[xl_lblk]) tgt = BW'(LOGN) + BW'(map_s[xl_lblk]);
    ok_c   = in_rng && !bad[tgt];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_pblk <= '0;
      out_ok   <= 1'b0;
    end else begin
      out_vld <= xl_vld;
      if (xl_vld) begin
        out_pblk <= tgt;
        out_ok   <= ok_c;
      end
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xl_vld |=> out_vld);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_vld |=> !out_vld);
  assert_block0_identity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_vld && xl_lblk == '0) |=> (out_pblk == '0 && out_ok));

endmodule

// File: rtl/bbt_remap.sv
module bbt_remap
  import bbt_pkg::*;
#(
  parameter int NB = 32,
  parameter int NS = 6,
  parameter int RW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_vld,
  input  logic [$clog2(NB)-1:0]      init_blk,
  input  logic                       init_done,
  output logic                       ready,
  input  logic                       op_vld,
  input  logic [$clog2(NB)-1:0]      op_blk,
  input  logic                       op_fail,
  input  logic [RW-1:0]              op_retries,
  input  logic [RW-1:0]              retry_limit,
  input  logic [$clog2(NS+1)-1:0]    warn_level,
  input  logic                       xl_vld,
  input  logic [$clog2(NB)-1:0]      xl_lblk,
  output logic                       xl_out_vld,
  output logic [$clog2(NB)-1:0]      xl_pblk,
  output logic                       xl_ok,
  output logic                       spare_warn,
  output logic                       fatal,
  output logic                       unrec
);

  localparam int BW   = $clog2(NB);
  localparam int SW   = $clog2(NS);
  localparam int CW   = $clog2(NS + 1);
  localparam int SB   = NB - 1 - NS;   // first spare block
  localparam int LOGN = SB;            // host-visible blocks 0..SB-1

  bbt_phase_e              phase;
  logic [BW-1:0]           sw_i;
  logic [NB-1:0]           bad;
  logic [LOGN-1:0]         map_v;
  logic [LOGN-1:0][SW-1:0] map_s;
  logic [NS-1:0]           sp_used;
  logic [NS-1:0][BW-1:0]   owner;

  // Named internal events
  logic [NS-1:0] free_vec;
  logic          avail;
  logic [SW-1:0] pick;
  logic [CW-1:0] remaining;
  logic          retire_mark;
  logic          op_is_spare;
  logic [SW-1:0] op_sp;
  logic          need_alloc;
  logic [BW-1:0] alloc_l;
  logic          init_take;
  logic          grant;

  for (genvar k = 0; k < NS; k++) begin : g_free
    assign free_vec[k] = !bad[SB + k] && !sp_used[k];
  end

  bbt_spare_pick #(.NS(NS), .SW(SW), .CW(CW)) u_pick (
    .free_vec  (free_vec),
    .avail     (avail),
    .pick      (pick),
    .remaining (remaining)
  );

  bbt_fail_judge #(.NB(NB), .BW(BW), .RW(RW)) u_judge (
    .run         (phase == PH_RUN),
    .op_vld      (op_vld),
    .op_blk      (op_blk),
    .op_fail     (op_fail),
    .op_retries  (op_retries),
    .retry_limit (retry_limit),
    .blk_bad     (bad[op_blk]),
    .mark        (retire_mark)
  );

  bbt_xlate #(.NB(NB), .BW(BW), .SW(SW), .LOGN(LOGN)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .xl_vld   (xl_vld),
    .xl_lblk  (xl_lblk),
    .map_v    (map_v),
    .map_s    (map_s),
    .bad      (bad),
    .out_vld  (xl_out_vld),
    .out_pblk (xl_pblk),
    .out_ok   (xl_ok)
  );

  assign op_is_spare = (int'(op_blk) >= SB) && (int'(op_blk) < SB + NS);
  assign op_sp       = SW'(op_blk - BW'(SB));
  assign init_take   = (phase == PH_LOAD) && init_vld && (init_blk != '0)
                       && (int'(init_blk) < NB - 1);
  assign grant       = need_alloc && avail;

  always_comb begin
    need_alloc = 1'b0;
    alloc_l    = '0;
    if (phase == PH_SWEEP) begin
      need_alloc = bad[sw_i] && !map_v[sw_i];
      alloc_l    = sw_i;
    end else if (retire_mark) begin
      if (int'(op_blk) < SB) begin
        need_alloc = 1'b1;
        alloc_l    = op_blk;
      end else if (op_is_spare && sp_used[op_sp]) begin
        need_alloc = 1'b1;
        alloc_l    = owner[op_sp];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_LOAD;
      sw_i    <= '0;
      bad     <= '0;
      map_v   <= '0;
      map_s   <= '0;
      sp_used <= '0;
      owner   <= '0;
      fatal   <= 1'b0;
      unrec   <= 1'b0;
    end else begin
      unrec <= 1'b0;
      case (phase)
        PH_LOAD: begin
          if (init_take) bad[init_blk] <= 1'b1;
          if (init_done) begin
            phase <= PH_SWEEP;
            sw_i  <= BW'(1);
          end
        end
        PH_SWEEP: begin
          sw_i <= sw_i + BW'(1);
          if (int'(sw_i) == SB - 1) phase <= PH_RUN;
        end
        default: begin
          if (retire_mark) bad[op_blk] <= 1'b1;
        end
      endcase
      if (need_alloc) begin
        if (avail) begin
          map_v[alloc_l] <= 1'b1;
          map_s[alloc_l] <= pick;
          sp_used[pick]  <= 1'b1;
          owner[pick]    <= alloc_l;
        end else begin
          fatal <= 1'b1;
          unrec <= 1'b1;
        end
      end
    end
  end

  assign ready      = (phase == PH_RUN);
  assign spare_warn = remaining < warn_level;

  assert_reserved_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bad[0] && !bad[NB-1]);
  assert_grant_fresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (!sp_used[pick] && !bad[SB + int'(pick)]));
  assert_spares_monotone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> (remaining <= $past(remaining)));
  assert_dup_no_spare_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && op_vld && bad[op_blk]) |=> (remaining == $past(remaining)));
  assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  assert_unrec_fatal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unrec |-> fatal);
  assert_quiet_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD) |=> (map_v == $past(map_v)));

endmodule

// File: tb/tb_bbt_remap.sv
module tb_bbt_remap;

  localparam int NB = 32;
  localparam int NS = 6;
  localparam int RW = 4;
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(NS + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_vld, init_done;
  logic [BW-1:0] init_blk;
  logic          ready;
  logic          op_vld, op_fail;
  logic [BW-1:0] op_blk;
  logic [RW-1:0] op_retries, retry_limit;
  logic [CW-1:0] warn_level;
  logic          xl_vld;
  logic [BW-1:0] xl_lblk;
  logic          xl_out_vld;
  logic [BW-1:0] xl_pblk;
  logic          xl_ok;
  logic          spare_warn, fatal, unrec;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bbt_remap #(.NB(NB), .NS(NS), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .init_vld(init_vld), .init_blk(init_blk), .init_done(init_done),
    .ready(ready),
    .op_vld(op_vld), .op_blk(op_blk), .op_fail(op_fail),
    .op_retries(op_retries), .retry_limit(retry_limit),
    .warn_level(warn_level),
    .xl_vld(xl_vld), .xl_lblk(xl_lblk),
    .xl_out_vld(xl_out_vld), .xl_pblk(xl_pblk), .xl_ok(xl_ok),
    .spare_warn(spare_warn), .fatal(fatal), .unrec(unrec)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int b);
    @(negedge clk);
    init_vld = 1'b1;
    init_blk = BW'(b);
    @(negedge clk);
    init_vld = 1'b0;
  endtask

  task automatic report(input int b, input logic f, input int r);
    @(negedge clk);
    op_vld     = 1'b1;
    op_blk     = BW'(b);
    op_fail    = f;
    op_retries = RW'(r);
    @(negedge clk);
    op_vld  = 1'b0;
    op_fail = 1'b0;
  endtask

  task automatic xlate(input string req, input int l, input int exp_p, input int exp_ok);
    @(negedge clk);
    xl_vld  = 1'b1;
    xl_lblk = BW'(l);
    @(negedge clk);
    xl_vld = 1'b0;
    chk(req, int'(xl_out_vld), 1);
    chk(req, int'(xl_pblk), exp_p);
    chk(req, int'(xl_ok), exp_ok);
    @(negedge clk);
    chk("R11", int'(xl_out_vld), 0);
  endtask

  // Scenario: reset state
  task automatic t_reset();
    chk("R2", int'(ready), 0);
    chk("R10", int'(fatal), 0);
    chk("R10", int'(unrec), 0);
    chk("R11", int'(xl_out_vld), 0);
    chk("R9", int'(spare_warn), 0);
  endtask

  // Scenario: factory list, early report ignored, sweep
  task automatic t_init();
    load(5);
    load(26);   // spare k=1
    load(31);   // reserved, ignored
    load(0);    // reserved, ignored
    report(9, 1'b1, 0);
    chk("R2", int'(ready), 0);
    @(negedge clk);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    chk("R2", int'(ready), 0);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    chk("R2", int'(ready), 1);
    xlate("R1", 5, 25, 1);
    xlate("R8", 0, 0, 1);
    xlate("R1", 7, 7, 1);
    xlate("R2", 9, 9, 1);
    xlate("R11", 26, 26, 0);
    chk("R9", int'(spare_warn), 0);
  endtask

  // Scenario: explicit failure, skip of defective spare 26
  task automatic t_fail();
    report(9, 1'b1, 0);
    xlate("R3", 9, 27, 1);
    chk("R5", int'(xl_pblk), 27);
    chk("R9", int'(spare_warn), 0);
  endtask

  // Scenario: retry boundary
  task automatic t_retry();
    report(10, 1'b0, 4);
    xlate("R4", 10, 10, 1);
    report(10, 1'b0, 5);
    xlate("R4", 10, 28, 1);
    chk("R9", int'(spare_warn), 1);
  endtask

  // Scenario: repeated report and reserved blocks
  task automatic t_dup_reserved();
    report(10, 1'b1, 0);
    chk("R7", int'(unrec), 0);
    xlate("R7", 10, 28, 1);
    report(0, 1'b1, 0);
    report(31, 1'b1, 0);
    xlate("R8", 0, 0, 1);
  endtask

  // Scenario: a serving spare fails; proves no spare was consumed above
  task automatic t_spare_fail();
    report(27, 1'b1, 0);
    xlate("R6", 9, 29, 1);
    chk("R7", int'(xl_pblk), 29);
    report(30, 1'b1, 0);   // idle spare retired, no host move
    chk("R5", int'(unrec), 0);
    chk("R5", int'(fatal), 0);
  endtask

  // Scenario: pool exhausted
  task automatic t_exhaust();
    report(12, 1'b1, 0);
    chk("R10", int'(unrec), 1);
    chk("R10", int'(fatal), 1);
    @(negedge clk);
    chk("R10", int'(unrec), 0);
    chk("R10", int'(fatal), 1);
    xlate("R10", 12, 12, 0);
    chk("R9", int'(spare_warn), 1);
    chk("R10", int'(fatal), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    init_vld = 1'b0; init_blk = '0; init_done = 1'b0;
    op_vld = 1'b0; op_blk = '0; op_fail = 1'b0; op_retries = '0;
    retry_limit = RW'(4);
    warn_level  = CW'(3);
    xl_vld = 1'b0; xl_lblk = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_init();
    t_fail();
    t_retry();
    t_dup_reserved();
    t_spare_fail();
    t_exhaust();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule